// File: doc/BRIEF.md
# Power-Good Hysteretic Window Monitor

This block watches a stream of signed feedback samples and decides whether the regulated output sits inside its regulation window around a reference value. It drives one active-low power-good level: low means "in regulation", high means "out". This matches an open-drain pin that sinks current while the output is good. The limits come from two percentages of the reference. The tight (static) limit defaults to 3 %. The loose (dynamic) limit defaults to 5 %. Both are derived with integer arithmetic, and the offsets are truncated so the window never grows.

The window depends on the direction the feedback is moving. While the feedback climbs, it counts as good from the lower static limit up to the upper dynamic limit. While it falls, it counts as good from the upper static limit down to the lower dynamic limit. The direction comes from comparing each new sample with the one before. After reset the monitor reports "out of regulation". It only qualifies once a sample lands inside the static band on both sides.

The control is a three-state machine:
- **ST_UNQUAL** is the reset state; no sample has qualified yet.
- **ST_GOOD** is in regulation.
- **ST_BAD** is out of regulation after a first qualification.

Its transitions are:
- **qualify** (ST_UNQUAL to ST_GOOD): a sample lands in the static band.
- **drop** (ST_GOOD to ST_BAD): a sample falls outside the directional window.
- **recover** (ST_BAD to ST_GOOD): a sample lands inside the directional window.

Every other strobe, and every cycle without a strobe, keeps the state.

Top module: `pg_window_monitor`

## Requirements
- R1: While reset is active and in the first cycle after it, `pg_n` is 1 (not good).
- R2: From reset, `pg_n` stays 1 until a strobed sample lies in [ref − s, ref + s], where s is the static offset. A sample that is only inside the dynamic band leaves `pg_n` at 1.
- R3: Once qualified, a strobed sample taken as rising gives `pg_n` = 0 exactly when ref − s ≤ fb ≤ ref + d, where d is the dynamic offset. Both bounds are inclusive.
- R4: Once qualified, a strobed sample taken as falling gives `pg_n` = 0 exactly when ref − d ≤ fb ≤ ref + s. Both bounds are inclusive.
- R5: The direction of a sample is set by comparing it with the previous strobed sample:
  - greater means rising;
  - smaller means falling;
  - equal keeps the previous direction.
  The first sample after reset is taken as rising.
- R6: The offsets are s = floor(ref·3/100) and d = floor(ref·5/100), with ref unsigned.
- R7: In a cycle without a strobe, `fb_smp` is ignored. Neither `pg_n`, the stored previous sample nor the stored direction changes.
- R8: `pg_n` changes on the rising clock edge that captures the strobe. Before that edge it still shows the previous decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | High for one cycle per new feedback sample |
| fb_smp | input | FB_W (12) | Signed feedback sample |
| ref_val | input | FB_W-1 (11) | Unsigned reference value |
| pg_n | output | 1 | Power-good, active low (0 = in regulation) |

## Verification
For each of several reference values, the feedback is swept one code at a time upward and then downward across the whole dynamic band. The references include zero, tiny values where truncation collapses the offsets, and the top of the range. The upward sweep finds the rising-window edges and the downward sweep finds the falling-window edges. The sweeps therefore separate a symmetric window from the direction-dependent one and show any off-by-one at each bound. Short directed sequences add the following cases:
- a first sample inside only the dynamic band, which separates the reset qualification rule from the plain window;
- a repeated equal sample, which shows whether the stored direction is kept;
- a stretch of idle cycles with a changing input, which shows that unstrobed data is ignored.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_UNQUAL = 2'd0,
        ST_GOOD   = 2'd1,
        ST_BAD    = 2'd2
    } pgw_state_e;

    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } pgw_dir_e;

    localparam int PGW_PCT_DEN = 100;

endpackage

// File: rtl/pgw_limits.sv
module pgw_limits #(
    parameter int FB_W       = 12,
    parameter int STATIC_PCT = 3,
    parameter int DYN_PCT    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FB_W-2:0]          ref_val,
    output logic signed [FB_W+1:0]   stat_lo,
    output logic signed [FB_W+1:0]   stat_hi,
    output logic signed [FB_W+1:0]   dyn_lo,
    output logic signed [FB_W+1:0]   dyn_hi
);
    import pgw_pkg::*;

    localparam int REF_W  = FB_W - 1;
    localparam int EXT_W  = FB_W + 2;
    localparam int PROD_W = REF_W + 8;

    logic [1:0][REF_W-1:0]   offs;
    logic signed [EXT_W-1:0] ref_ext;
    logic signed [EXT_W-1:0] s_ext;
    logic signed [EXT_W-1:0] d_ext;

    for (genvar g = 0; g < 2; g++) begin : g_off
        localparam int PCT = (g == 0) ? STATIC_PCT : DYN_PCT;
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] off_wide;

        assign prod     = PROD_W'(ref_val) * PROD_W'(PCT);
        assign offs[g]  = REF_W'(prod / PROD_W'(PGW_PCT_DEN));
        assign off_wide = PROD_W'(offs[g]);

        // R6: offset is the truncated quotient, never rounded up
        a_r6_trunc: assert property (@(posedge clk) disable iff (!rst_n)
            (off_wide * PROD_W'(PGW_PCT_DEN) <= prod) &&
            (prod < (off_wide + PROD_W'(1)) * PROD_W'(PGW_PCT_DEN)));
    end

    assign ref_ext = $signed({{(EXT_W-REF_W){1'b0}}, ref_val});
    assign s_ext   = $signed({{(EXT_W-REF_W){1'b0}}, offs[0]});
    assign d_ext   = $signed({{(EXT_W-REF_W){1'b0}}, offs[1]});

    assign stat_lo = ref_ext - s_ext;
    assign stat_hi = ref_ext + s_ext;
    assign dyn_lo  = ref_ext - d_ext;
    assign dyn_hi  = ref_ext + d_ext;

endmodule

// File: rtl/pgw_slope.sv
module pgw_slope #(
    parameter int FB_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic signed [FB_W-1:0] fb_smp,
    output pgw_pkg::pgw_dir_e      dir_cur
);
    import pgw_pkg::*;

    logic signed [FB_W-1:0] prev_q;
    logic                   have_prev_q;
    pgw_dir_e               dir_q;

    always_comb begin
        dir_cur = dir_q;
        if (have_prev_q) begin
            if (fb_smp > prev_q) begin
                dir_cur = DIR_RISE;
            end else if (fb_smp < prev_q) begin
                dir_cur = DIR_FALL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            dir_q       <= DIR_RISE;
        end else if (smp_valid) begin
            prev_q      <= fb_smp;
            have_prev_q <= 1'b1;
            dir_q       <= dir_cur;
        end
    end

    // R5: a larger sample than the stored one is recorded as rising
    a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && have_prev_q && (fb_smp > prev_q)) |=> (dir_q == DIR_RISE));

    // R5: a smaller sample is recorded as falling
    a_r5_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && have_prev_q && (fb_smp < prev_q)) |=> (dir_q == DIR_FALL));

    // R5: an equal sample keeps the stored direction
    a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && have_prev_q && (fb_smp == prev_q)) |=> $stable(dir_q));

    // R7: without a strobe the stored history does not move
    a_r7_hist: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(prev_q) && $stable(dir_q) && $stable(have_prev_q)));

endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm #(
    parameter int EXT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [EXT_W-1:0] fb_ext,
    input  pgw_pkg::pgw_dir_e       dir_cur,
    input  logic signed [EXT_W-1:0] stat_lo,
    input  logic signed [EXT_W-1:0] stat_hi,
    input  logic signed [EXT_W-1:0] dyn_lo,
    input  logic signed [EXT_W-1:0] dyn_hi,
    output logic                    pg_n
);
    import pgw_pkg::*;

    pgw_state_e              state_q;
    pgw_state_e              state_d;
    logic signed [EXT_W-1:0] win_lo;
    logic signed [EXT_W-1:0] win_hi;
    logic                    in_static;
    logic                    in_win;

    assign in_static = (fb_ext >= stat_lo) && (fb_ext <= stat_hi);
    assign win_lo    = (dir_cur == DIR_RISE) ? stat_lo : dyn_lo;
    assign win_hi    = (dir_cur == DIR_RISE) ? dyn_hi  : stat_hi;
    assign in_win    = (fb_ext >= win_lo) && (fb_ext <= win_hi);

    always_comb begin
        state_d = state_q;
        if (smp_valid) begin
            unique case (state_q)
                ST_UNQUAL: if (in_static) state_d = ST_GOOD;   // qualify
                ST_GOOD:   if (!in_win)   state_d = ST_BAD;    // drop
                ST_BAD:    if (in_win)    state_d = ST_GOOD;   // recover
                default:                  state_d = ST_UNQUAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNQUAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_GOOD:   pg_n = 1'b0;
            ST_BAD:    pg_n = 1'b1;
            ST_UNQUAL: pg_n = 1'b1;
            default:   pg_n = 1'b1;
        endcase
    end

    // R2: an unqualified monitor ignores samples outside the static band
    a_r2_unqual: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNQUAL && smp_valid && !in_static) |=> pg_n);

    // R2: once qualified the monitor never goes back to the reset state
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_UNQUAL) |=> (state_q != ST_UNQUAL));

    // R7: output frozen between strobes
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(pg_n));

endmodule

// File: rtl/pg_window_monitor.sv
module pg_window_monitor #(
    parameter int FB_W       = 12,
    parameter int STATIC_PCT = 3,
    parameter int DYN_PCT    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic signed [FB_W-1:0] fb_smp,
    input  logic [FB_W-2:0]        ref_val,
    output logic                   pg_n
);
    import pgw_pkg::*;

    localparam int EXT_W = FB_W + 2;

    logic signed [EXT_W-1:0] fb_ext;
    logic signed [EXT_W-1:0] stat_lo;
    logic signed [EXT_W-1:0] stat_hi;
    logic signed [EXT_W-1:0] dyn_lo;
    logic signed [EXT_W-1:0] dyn_hi;
    pgw_dir_e                dir_cur;

    assign fb_ext = {{(EXT_W-FB_W){fb_smp[FB_W-1]}}, fb_smp};

    pgw_limits #(
        .FB_W       (FB_W),
        .STATIC_PCT (STATIC_PCT),
        .DYN_PCT    (DYN_PCT)
    ) u_limits (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_val (ref_val),
        .stat_lo (stat_lo),
        .stat_hi (stat_hi),
        .dyn_lo  (dyn_lo),
        .dyn_hi  (dyn_hi)
    );

    pgw_slope #(
        .FB_W (FB_W)
    ) u_slope (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .fb_smp    (fb_smp),
        .dir_cur   (dir_cur)
    );

    pgw_fsm #(
        .EXT_W (EXT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .fb_ext    (fb_ext),
        .dir_cur   (dir_cur),
        .stat_lo   (stat_lo),
        .stat_hi   (stat_hi),
        .dyn_lo    (dyn_lo),
        .dyn_hi    (dyn_hi),
        .pg_n      (pg_n)
    );

    // R1: output reads "not good" while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset: assert (pg_n);
        end
    end

    // R3: after qualification a rising sample in the climbing window leaves pg_n low
    a_r3_rise_good: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !pg_n && dir_cur == DIR_RISE &&
         fb_ext >= stat_lo && fb_ext <= dyn_hi) |=> !pg_n);

    // R4: a falling sample in the descending window leaves pg_n low
    a_r4_fall_good: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !pg_n && dir_cur == DIR_FALL &&
         fb_ext >= dyn_lo && fb_ext <= stat_hi) |=> !pg_n);

    // R3, R4: anything outside the dynamic band always reads not good
    a_r4_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (fb_ext < dyn_lo || fb_ext > dyn_hi)) |=> pg_n);

endmodule

// File: tb/pg_window_monitor_bench.sv
module pg_window_monitor_bench;

    localparam int FB_W  = 12;
    localparam int REF_W = FB_W - 1;
    localparam int FB_MIN = -(1 << (FB_W - 1));
    localparam int FB_MAX = (1 << (FB_W - 1)) - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   smp_valid = 1'b0;
    logic signed [FB_W-1:0] fb_smp = '0;
    logic [REF_W-1:0]       ref_val = '0;
    logic                   pg_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    bit  m_qual, m_good, m_rise, m_have;
    int  m_prev;
    int  cur_ref;

    always #10 clk = ~clk;

    pg_window_monitor #(.FB_W(FB_W)) u_pg_window_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .fb_smp    (fb_smp),
        .ref_val   (ref_val),
        .pg_n      (pg_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ref=%0d actual=%b expected=%b t=%0t", tag, cur_ref, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int r);
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; ref_val = REF_W'(r); cur_ref = r;
        m_qual = 0; m_good = 0; m_rise = 1; m_have = 0; m_prev = 0;
        repeat (2) @(negedge clk);
        check(pg_n, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pg_n, 1'b1, "R1 after reset");
    endtask

    task automatic apply(input int v, input string tag);
        int  s3, s5, lo, hi;
        bit  instat, inwin;
        logic old_exp;
        s3 = (cur_ref * 3) / 100;
        s5 = (cur_ref * 5) / 100;
        old_exp = !m_good;
        if (m_have) begin
            if (v > m_prev) m_rise = 1;
            else if (v < m_prev) m_rise = 0;
        end
        m_have = 1; m_prev = v;
        lo = m_rise ? cur_ref - s3 : cur_ref - s5;
        hi = m_rise ? cur_ref + s5 : cur_ref + s3;
        inwin  = (v >= lo) && (v <= hi);
        instat = (v >= cur_ref - s3) && (v <= cur_ref + s3);
        if (!m_qual) begin
            if (instat) begin m_qual = 1; m_good = 1; end
            else m_good = 0;
        end else begin
            m_good = inwin;
        end
        fb_smp = FB_W'(v);
        smp_valid = 1'b1;
        #2;
        check(pg_n, old_exp, "R8 before edge");
        @(negedge clk);
        smp_valid = 1'b0;
        check(pg_n, !m_good, tag);
    endtask

    task automatic idle_hold(input int v);
        logic old_exp;
        old_exp = !m_good;
        for (int k = 0; k < 3; k++) begin
            fb_smp = FB_W'(v + k * 37);
            @(negedge clk);
            check(pg_n, old_exp, "R7 idle ignored");
        end
    endtask

    task automatic run_ref(input int r);
        int s3, s5, lo, hi;
        do_reset(r);
        s3 = (r * 3) / 100;
        s5 = (r * 5) / 100;
        if (s5 > s3) apply(r + s5, "R2 dynamic-only first sample");
        lo = (r - s5 - 6 < FB_MIN) ? FB_MIN : r - s5 - 6;
        hi = (r + s5 + 6 > FB_MAX) ? FB_MAX : r + s5 + 6;
        for (int v = lo; v <= hi; v++) apply(v, "R3/R6 rising sweep");
        for (int v = hi; v >= lo; v--) apply(v, "R4/R6 falling sweep");
        idle_hold(r);
        apply(lo, "R7 history kept");
        apply(r, "R5 rise into window");
        if (r + s5 <= FB_MAX) begin
            apply(r + s5, "R5 rising at dynamic edge");
            apply(r + s5, "R5 equal keeps rising");
            apply(r + s5 - 1, "R5 fall above static edge");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        run_ref(0);
        run_ref(1);
        run_ref(34);
        run_ref(100);
        run_ref(1000);
        run_ref(1999);
        run_ref(2047);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule